// File: doc/BRIEF.md
# Paired-channel energy and time estimator

This block turns raw pulse samples into a calibrated energy and a time estimate, two channels at a time. Every transfer carries, for each of its two lanes, five unsigned 12-bit samples, two sets of five signed 16-bit weights, two 32-bit signed offsets, a 16-bit energy scale factor, a 16-bit reciprocal-of-energy value and a 5-bit magnitude exponent. The reciprocal value is looked up elsewhere and arrives with the channel. The block forms two weighted sums over the samples and removes an offset from each. The first sum becomes the energy after a rounded fixed-point scale. The second sum is multiplied by the reciprocal and shifted right by the exponent to give the time.

A signed energy threshold and a bypass flag are configuration inputs. When bypass is low, a channel whose scaled energy is zero, negative or below the threshold gets no time: its time word is zero and its time-valid flag is low. The datapath is a two-stage pipeline with a valid/ready handshake on both sides. Both configuration inputs are sampled as a result enters the output stage, so they must be held steady while results are in flight.

Top module: `ofet_core`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: A lane's raw energy is sum(a_i * s_i) for i = 0..4, minus the signed pedestal, kept modulo 2^32. Samples s_i are unsigned 12-bit and weights a_i are signed 16-bit. Sample i of a lane sits at bits [12i+11:12i] of the lane's sample slice, and weight i sits at bits [16i+15:16i] of the lane's weight slice.
- R3: The output energy is bits [45:14] of (raw energy * signed 16-bit scale + 8192). A product exactly halfway between two output steps rounds toward plus infinity.
- R4: The raw time is formed like R2 from the time weights and the time pedestal. The time output is the low 32 bits of (raw time * unsigned 16-bit reciprocal), arithmetically shifted right by the 5-bit exponent.
- R5: With bypass low, a lane whose output energy is below the signed threshold gets time_valid low and a time word of zero. An energy equal to the threshold is not below it.
- R6: With bypass low, an output energy of zero or less gives time_valid low whatever the threshold is.
- R7: With bypass high, every lane gets time_valid high and its time from R4, even for zero or negative energy.
- R8: A transfer accepted at clock edge k gives out_valid after edge k+1 when out_ready is high. Results leave in acceptance order at up to one per cycle, and in_ready falls only while an undelivered result is held at the output.
- R9: While out_valid is high and out_ready is low, all output ports hold their values.
- R10: Each transfer carries two channels. Lane l occupies slice [l*W +: W] of every packed port, where W is that port's per-lane width. Each lane's results depend only on its own slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_samp | input | 120 | Five 12-bit samples per lane |
| in_acoef | input | 160 | Five signed energy weights per lane |
| in_aped | input | 64 | Signed energy pedestal per lane |
| in_scale | input | 32 | Signed energy scale factor per lane |
| in_bcoef | input | 160 | Five signed time weights per lane |
| in_bped | input | 64 | Signed time pedestal per lane |
| in_recip | input | 32 | Unsigned reciprocal-of-energy per lane |
| in_mexp | input | 10 | Time right-shift exponent per lane |
| cfg_cut | input | 32 | Signed energy threshold for time computation |
| cfg_bypass | input | 1 | Force time computation for all lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken by consumer |
| out_energy | output | 64 | Scaled energy per lane |
| out_time | output | 64 | Time estimate per lane |
| out_tvalid | output | 2 | Time computed flag per lane |

## Verification
The hardest cases to reach are energies that sit exactly on a decision point: a scaled energy equal to the threshold, or one step below it, and a scaled product exactly halfway between two output steps, for both signs. Random weights almost never produce these. The stimulus builds them directly: a single nonzero weight and a scale of one half or one give a known small raw energy. A second hard case is a held output while the first stage is also full. Random out_ready stalls during long back-to-back streams push the pipeline into that state over and over, and the order and stability of results are checked throughout.

// File: rtl/ofet_pkg.sv
package ofet_pkg;
   localparam int OFET_LANES    = 2;
   localparam int OFET_NSAMP    = 5;
   localparam int OFET_SAMP_W   = 12;
   localparam int OFET_COEF_W   = 16;
   localparam int OFET_PED_W    = 32;
   localparam int OFET_SCALE_W  = 16;
   localparam int OFET_RECIP_W  = 16;
   localparam int OFET_EXP_W    = 5;
   localparam int OFET_FRAC_SH  = 14;
   localparam int OFET_OUT_W    = 32;
endpackage

// File: rtl/ofet_dot.sv
// Weighted sum of unsigned samples with signed weights, minus a signed offset.
module ofet_dot
   import ofet_pkg::*;
#(
   parameter int NSAMP  = OFET_NSAMP,
   parameter int SAMP_W = OFET_SAMP_W,
   parameter int COEF_W = OFET_COEF_W,
   parameter int PED_W  = OFET_PED_W
) (
   input  logic [NSAMP*SAMP_W-1:0] samp,
   input  logic [NSAMP*COEF_W-1:0] coef,
   input  logic [PED_W-1:0]        ped,
   output logic [PED_W-1:0]        acc
);
   localparam int PROD_W = COEF_W + SAMP_W + 1;
   localparam int SUM_W  = PROD_W + $clog2(NSAMP) + 1;
   localparam int WIDE_W = ((SUM_W > PED_W) ? SUM_W : PED_W) + 1;

   logic [PROD_W-1:0] prod [NSAMP];

   for (genvar i = 0; i < NSAMP; i++) begin : g_mul
      logic [PROD_W-1:0] c_ext;
      logic [PROD_W-1:0] s_ext;
      assign c_ext   = {{(PROD_W-COEF_W){coef[i*COEF_W+COEF_W-1]}}, coef[i*COEF_W +: COEF_W]};
      assign s_ext   = {{(PROD_W-SAMP_W){1'b0}}, samp[i*SAMP_W +: SAMP_W]};
      assign prod[i] = c_ext * s_ext;
   end

   logic [WIDE_W-1:0] sum_w;
   always_comb begin
      sum_w = '0;
      for (int i = 0; i < NSAMP; i++) begin
         sum_w = sum_w + {{(WIDE_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
      end
      sum_w = sum_w - {{(WIDE_W-PED_W){ped[PED_W-1]}}, ped};
   end

   assign acc = sum_w[PED_W-1:0];

   logic [WIDE_W-1:0] unused_sum;
   assign unused_sum = sum_w;
endmodule

// File: rtl/ofet_post.sv
// Energy scaling with rounding, threshold decision and time product/shift.
module ofet_post
   import ofet_pkg::*;
#(
   parameter int ACC_W   = OFET_PED_W,
   parameter int SCALE_W = OFET_SCALE_W,
   parameter int RECIP_W = OFET_RECIP_W,
   parameter int EXP_W   = OFET_EXP_W,
   parameter int FRAC_SH = OFET_FRAC_SH,
   parameter int OUT_W   = OFET_OUT_W
) (
   input  logic [ACC_W-1:0]   e_raw,
   input  logic [ACC_W-1:0]   t_raw,
   input  logic [SCALE_W-1:0] scale,
   input  logic [RECIP_W-1:0] recip,
   input  logic [EXP_W-1:0]   mexp,
   input  logic [OUT_W-1:0]   cut,
   input  logic               bypass,
   output logic [OUT_W-1:0]   energy,
   output logic [OUT_W-1:0]   time_o,
   output logic               tvalid
);
   localparam int EP_W = ACC_W + SCALE_W;
   localparam int TP_W = ACC_W + RECIP_W + 1;
   localparam logic [EP_W-1:0] RND = EP_W'(1) << (FRAC_SH - 1);

   logic [EP_W-1:0] e_a, e_b, e_prod, e_rnd;
   assign e_a    = {{SCALE_W{e_raw[ACC_W-1]}}, e_raw};
   assign e_b    = {{ACC_W{scale[SCALE_W-1]}}, scale};
   assign e_prod = e_a * e_b;
   assign e_rnd  = e_prod + RND;
   assign energy = e_rnd[FRAC_SH +: OUT_W];

   logic signed [TP_W-1:0] t_a, t_b, t_prod, t_sh;
   assign t_a    = {{(RECIP_W+1){t_raw[ACC_W-1]}}, t_raw};
   assign t_b    = {{(ACC_W+1){1'b0}}, recip};
   assign t_prod = t_a * t_b;
   assign t_sh   = t_prod >>> mexp;

   logic e_pos, pass;
   assign e_pos  = !energy[OUT_W-1] && (|energy);
   assign pass   = bypass || (e_pos && ($signed(energy) >= $signed(cut)));
   assign tvalid = pass;
   assign time_o = pass ? t_sh[OUT_W-1:0] : '0;

   logic [EP_W-1:0] unused_rnd;
   logic [TP_W-1:0] unused_tsh;
   assign unused_rnd = e_rnd;
   assign unused_tsh = t_sh;
endmodule

// File: rtl/ofet_core.sv
module ofet_core
   import ofet_pkg::*;
#(
   parameter int LANES   = OFET_LANES,
   parameter int NSAMP   = OFET_NSAMP,
   parameter int SAMP_W  = OFET_SAMP_W,
   parameter int COEF_W  = OFET_COEF_W,
   parameter int PED_W   = OFET_PED_W,
   parameter int SCALE_W = OFET_SCALE_W,
   parameter int RECIP_W = OFET_RECIP_W,
   parameter int EXP_W   = OFET_EXP_W,
   parameter int FRAC_SH = OFET_FRAC_SH,
   parameter int OUT_W   = OFET_OUT_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [LANES*NSAMP*SAMP_W-1:0] in_samp,
   input  logic [LANES*NSAMP*COEF_W-1:0] in_acoef,
   input  logic [LANES*PED_W-1:0]     in_aped,
   input  logic [LANES*SCALE_W-1:0]   in_scale,
   input  logic [LANES*NSAMP*COEF_W-1:0] in_bcoef,
   input  logic [LANES*PED_W-1:0]     in_bped,
   input  logic [LANES*RECIP_W-1:0]   in_recip,
   input  logic [LANES*EXP_W-1:0]     in_mexp,
   input  logic [OUT_W-1:0]           cfg_cut,
   input  logic                       cfg_bypass,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [LANES*OUT_W-1:0]     out_energy,
   output logic [LANES*OUT_W-1:0]     out_time,
   output logic [LANES-1:0]           out_tvalid
);
   localparam int LSAMP_W = NSAMP * SAMP_W;
   localparam int LCOEF_W = NSAMP * COEF_W;

   if (LANES < 1 || NSAMP < 1) begin : g_bad_count
      $error("ofet_core: LANES and NSAMP must be positive");
   end
   if (FRAC_SH < 1 || FRAC_SH + OUT_W > PED_W + SCALE_W) begin : g_bad_frac
      $error("ofet_core: energy field does not fit the scaled product");
   end
   if (OUT_W > PED_W + RECIP_W + 1) begin : g_bad_time
      $error("ofet_core: time field wider than its product");
   end

   // Two-stage pipeline control
   logic v1_q, v2_q, adv2, take_in, load2;
   assign adv2     = !v2_q || out_ready;
   assign in_ready = !v1_q || adv2;
   assign take_in  = in_valid && in_ready;
   assign load2    = v1_q && adv2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
      end else begin
         if (in_ready) v1_q <= in_valid;
         if (adv2)     v2_q <= v1_q;
      end
   end
   assign out_valid = v2_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [PED_W-1:0]   e_raw_d, t_raw_d, e_raw_q, t_raw_q;
      logic [SCALE_W-1:0] scale_q;
      logic [RECIP_W-1:0] recip_q;
      logic [EXP_W-1:0]   mexp_q;
      logic [OUT_W-1:0]   e_d, t_d, e_q, t_q;
      logic               tv_d, tv_q;

      ofet_dot #(.NSAMP(NSAMP), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .PED_W(PED_W)) u_edot (
         .samp (in_samp[l*LSAMP_W +: LSAMP_W]),
         .coef (in_acoef[l*LCOEF_W +: LCOEF_W]),
         .ped  (in_aped[l*PED_W +: PED_W]),
         .acc  (e_raw_d)
      );
      ofet_dot #(.NSAMP(NSAMP), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .PED_W(PED_W)) u_tdot (
         .samp (in_samp[l*LSAMP_W +: LSAMP_W]),
         .coef (in_bcoef[l*LCOEF_W +: LCOEF_W]),
         .ped  (in_bped[l*PED_W +: PED_W]),
         .acc  (t_raw_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_raw_q <= '0;
            t_raw_q <= '0;
            scale_q <= '0;
            recip_q <= '0;
            mexp_q  <= '0;
         end else if (take_in) begin
            e_raw_q <= e_raw_d;
            t_raw_q <= t_raw_d;
            scale_q <= in_scale[l*SCALE_W +: SCALE_W];
            recip_q <= in_recip[l*RECIP_W +: RECIP_W];
            mexp_q  <= in_mexp[l*EXP_W +: EXP_W];
         end
      end

      ofet_post #(.ACC_W(PED_W), .SCALE_W(SCALE_W), .RECIP_W(RECIP_W), .EXP_W(EXP_W),
                  .FRAC_SH(FRAC_SH), .OUT_W(OUT_W)) u_post (
         .e_raw  (e_raw_q),
         .t_raw  (t_raw_q),
         .scale  (scale_q),
         .recip  (recip_q),
         .mexp   (mexp_q),
         .cut    (cfg_cut),
         .bypass (cfg_bypass),
         .energy (e_d),
         .time_o (t_d),
         .tvalid (tv_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_q  <= '0;
            t_q  <= '0;
            tv_q <= 1'b0;
         end else if (load2) begin
            e_q  <= e_d;
            t_q  <= t_d;
            tv_q <= tv_d;
         end
      end

      assign out_energy[l*OUT_W +: OUT_W] = e_q;
      assign out_time[l*OUT_W +: OUT_W]   = t_q;
      assign out_tvalid[l]                = tv_q;
   end
endmodule

// File: rtl/ofet_core_chk.sv
module ofet_core_chk #(
   parameter int LANES = 2,
   parameter int OUT_W = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [LANES*OUT_W-1:0] out_energy,
   input logic [LANES*OUT_W-1:0] out_time,
   input logic [LANES-1:0]       out_tvalid,
   input logic [OUT_W-1:0]       cfg_cut,
   input logic                   cfg_bypass
);
   // R1
   a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R8: input stalls only behind a held result
   a_r8_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready));

   // R9
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_energy)
                                     && $stable(out_time) && $stable(out_tvalid)));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      // R5
      a_r5_below_cut: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !cfg_bypass
          && ($signed(out_energy[l*OUT_W +: OUT_W]) < $signed(cfg_cut))) |-> !out_tvalid[l]);
      // R5: suppressed time reads zero
      a_r5_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_tvalid[l]) |-> (out_time[l*OUT_W +: OUT_W] == '0));
      // R6
      a_r6_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !cfg_bypass
          && ($signed(out_energy[l*OUT_W +: OUT_W]) <= 0)) |-> !out_tvalid[l]);
      // R7
      a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && cfg_bypass) |-> out_tvalid[l]);
   end
endmodule

bind ofet_core ofet_core_chk #(.LANES(LANES), .OUT_W(OUT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_energy (out_energy),
   .out_time   (out_time),
   .out_tvalid (out_tvalid),
   .cfg_cut    (cfg_cut),
   .cfg_bypass (cfg_bypass)
);

// File: tb/ofet_core_bench.sv
module ofet_core_bench;
   localparam int CLK_NS = 10;

   typedef struct packed {
      logic [4:0][11:0] s;
      logic [4:0][15:0] a;
      logic [31:0]      aped;
      logic [15:0]      sc;
      logic [4:0][15:0] b;
      logic [31:0]      bped;
      logic [15:0]      rc;
      logic [4:0]       m;
   } chan_t;

   typedef struct packed {
      logic [1:0][31:0] e;
      logic [1:0][31:0] t;
      logic [1:0]       tv;
   } res_t;

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid, in_ready;
   logic [119:0] in_samp;
   logic [159:0] in_acoef, in_bcoef;
   logic [63:0]  in_aped, in_bped;
   logic [31:0]  in_scale, in_recip;
   logic [9:0]   in_mexp;
   logic signed [31:0] cfg_cut;
   logic cfg_bypass;
   logic out_valid, out_ready;
   logic [63:0] out_energy, out_time;
   logic [1:0]  out_tvalid;

   always #(CLK_NS/2) clk = ~clk;

   ofet_core u_ofet_core (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_samp(in_samp), .in_acoef(in_acoef), .in_aped(in_aped), .in_scale(in_scale),
      .in_bcoef(in_bcoef), .in_bped(in_bped), .in_recip(in_recip), .in_mexp(in_mexp),
      .cfg_cut(cfg_cut), .cfg_bypass(cfg_bypass), .out_valid(out_valid),
      .out_ready(out_ready), .out_energy(out_energy), .out_time(out_time),
      .out_tvalid(out_tvalid)
   );

   int total = 0;
   int bad = 0;
   logic bp_en = 1'b0;
   res_t exp_q[$];
   string tag_q[$];

   task automatic chk(string req, bit ok, string act, string expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%s expected=%s", req, act, expv);
      end
   endtask

   function automatic void model(input chan_t c, output logic [31:0] e,
                                 output logic [31:0] t, output logic tv);
      longint acc;
      longint p;
      logic signed [31:0] raw;
      acc = 0;
      for (int i = 0; i < 5; i++) acc += longint'($signed(c.a[i])) * longint'({1'b0, c.s[i]});
      acc -= longint'($signed(c.aped));
      raw = acc[31:0];
      p = longint'(raw) * longint'($signed(c.sc));
      p = (p + 64'sd8192) >>> 14;
      e = p[31:0];
      tv = cfg_bypass || (($signed(e) > 0) && ($signed(e) >= cfg_cut));
      acc = 0;
      for (int i = 0; i < 5; i++) acc += longint'($signed(c.b[i])) * longint'({1'b0, c.s[i]});
      acc -= longint'($signed(c.bped));
      raw = acc[31:0];
      p = longint'(raw) * longint'({1'b0, c.rc});
      p = p >>> c.m;
      t = tv ? p[31:0] : 32'd0;
   endfunction

   function automatic res_t predict(chan_t c0, chan_t c1);
      res_t r;
      logic [31:0] e, t;
      logic tv;
      model(c0, e, t, tv); r.e[0] = e; r.t[0] = t; r.tv[0] = tv;
      model(c1, e, t, tv); r.e[1] = e; r.t[1] = t; r.tv[1] = tv;
      return r;
   endfunction

   task automatic drive(chan_t c0, chan_t c1);
      in_samp  = {c1.s, c0.s};
      in_acoef = {c1.a, c0.a};
      in_aped  = {c1.aped, c0.aped};
      in_scale = {c1.sc, c0.sc};
      in_bcoef = {c1.b, c0.b};
      in_bped  = {c1.bped, c0.bped};
      in_recip = {c1.rc, c0.rc};
      in_mexp  = {c1.m, c0.m};
   endtask

   task automatic send(chan_t c0, chan_t c1, string tag);
      @(negedge clk);
      drive(c0, c1);
      in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      exp_q.push_back(predict(c0, c1));
      tag_q.push_back(tag);
      @(posedge clk);
   endtask

   task automatic drain();
      @(negedge clk);
      in_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   function automatic chan_t zero_chan();
      chan_t c;
      c = '0;
      c.sc = 16'd16384;
      return c;
   endfunction

   function automatic chan_t rnd_chan();
      chan_t c;
      for (int i = 0; i < 5; i++) begin
         c.s[i] = 12'($urandom);
         c.a[i] = 16'($urandom);
         c.b[i] = 16'($urandom);
      end
      c.aped = $urandom;
      c.bped = $urandom;
      c.sc   = 16'($urandom);
      c.rc   = 16'($urandom);
      c.m    = 5'($urandom);
      return c;
   endfunction

   // Consumer readiness
   initial begin
      out_ready = 1'b1;
      forever begin
         @(negedge clk);
         out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      end
   end

   // Monitor / scoreboard
   initial begin
      logic held;
      logic [63:0] h_e, h_t;
      logic [1:0] h_tv;
      held = 1'b0;
      h_e = '0; h_t = '0; h_tv = '0;
      forever begin
         @(negedge clk);
         #2;
         if (held) begin
            chk("R9", out_valid && out_energy == h_e && out_time == h_t && out_tvalid == h_tv,
                $sformatf("v=%0b e=%h t=%h tv=%b", out_valid, out_energy, out_time, out_tvalid),
                $sformatf("v=1 e=%h t=%h tv=%b", h_e, h_t, h_tv));
         end
         held = out_valid && !out_ready;
         if (held) begin
            h_e = out_energy; h_t = out_time; h_tv = out_tvalid;
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk("R8", 1'b0, "unexpected result", "no result");
            end else begin
               res_t r;
               string tg;
               r  = exp_q.pop_front();
               tg = tag_q.pop_front();
               for (int l = 0; l < 2; l++) begin
                  chk($sformatf("%s R10 lane%0d", tg, l),
                      out_energy[l*32 +: 32] == r.e[l] && out_time[l*32 +: 32] == r.t[l]
                      && out_tvalid[l] == r.tv[l],
                      $sformatf("e=%h t=%h tv=%b", out_energy[l*32 +: 32], out_time[l*32 +: 32], out_tvalid[l]),
                      $sformatf("e=%h t=%h tv=%b", r.e[l], r.t[l], r.tv[l]));
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      chan_t c0, c1;
      rst_n = 1'b0;
      in_valid = 1'b0;
      drive('0, '0);
      cfg_cut = 32'sd0;
      cfg_bypass = 1'b0;
      repeat (3) @(negedge clk);
      #3;
      chk("R1", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
      rst_n = 1'b1;
      @(negedge clk);
      #3;
      chk("R1", out_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("v=%0b rdy=%0b", out_valid, in_ready), "v=0 rdy=1");

      // R8 latency: one transfer, out_valid one edge after the capture edge stays low
      c0 = zero_chan(); c0.s[0] = 12'd7; c0.a[0] = 16'd3;
      c1 = zero_chan(); c1.s[1] = 12'd9; c1.a[1] = 16'd2;
      @(negedge clk);
      drive(c0, c1);
      in_valid = 1'b1;
      #1;
      exp_q.push_back(predict(c0, c1));
      tag_q.push_back("R8");
      @(negedge clk);
      in_valid = 1'b0;
      #3;
      chk("R8", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
      @(negedge clk);
      #3;
      chk("R8", out_valid == 1'b1, $sformatf("%0b", out_valid), "1");
      drain();

      // R2: plain weighted sum with unity scale, both lanes different (R10)
      c0 = zero_chan();
      for (int i = 0; i < 5; i++) begin
         c0.s[i] = 12'(100 * (i + 1));
         c0.a[i] = 16'(i + 1);
      end
      c0.aped = 32'd500;
      c1 = zero_chan();
      c1.s[0] = 12'd4095; c1.s[4] = 12'd4095;
      c1.a[0] = 16'hFFFF; c1.a[4] = 16'h8000;
      c1.aped = 32'hFFFF_FF00;
      send(c0, c1, "R2");
      drain();

      // R3: half-way rounding, positive and negative
      c0 = zero_chan(); c0.s[0] = 12'd3; c0.a[0] = 16'd1;      c0.sc = 16'd8192;
      c1 = zero_chan(); c1.s[0] = 12'd3; c1.a[0] = 16'hFFFF;   c1.sc = 16'd8192;
      send(c0, c1, "R3");
      c0.sc = 16'h8000; c1.sc = 16'd5000;
      send(c0, c1, "R3");
      drain();

      // R4: time product and shift, negative and positive raw time
      cfg_bypass = 1'b1;
      c0 = zero_chan(); c0.s[2] = 12'd1000; c0.b[2] = 16'hF000; c0.bped = 32'd77;
      c0.rc = 16'd40000; c0.m = 5'd3;
      c1 = zero_chan(); c1.s[3] = 12'd4000; c1.b[3] = 16'h7FFF; c1.bped = 32'hFFFF_0000;
      c1.rc = 16'hFFFF; c1.m = 5'd31;
      send(c0, c1, "R4");
      c0.m = 5'd0; c1.m = 5'd17;
      send(c0, c1, "R4");
      drain();

      // R5: energy equal to the threshold and one step below
      cfg_bypass = 1'b0;
      cfg_cut = 32'sd5000;
      c0 = zero_chan(); c0.s[0] = 12'd4095; c0.s[1] = 12'd905; c0.a[0] = 16'd1; c0.a[1] = 16'd1;
      c0.b[0] = 16'd9; c0.rc = 16'd300; c0.m = 5'd2;
      c1 = c0; c1.s[1] = 12'd904;
      send(c0, c1, "R5");
      drain();

      // R6: zero and negative energy with a negative threshold
      cfg_cut = -32'sd100;
      c0 = zero_chan(); c0.b[0] = 16'd5; c0.s[0] = 12'd10; c0.rc = 16'd1000;
      c1 = c0; c1.a[0] = 16'hFFFF;
      send(c0, c1, "R6");
      drain();

      // R7: bypass forces time on the same nonpositive energies
      cfg_bypass = 1'b1;
      send(c0, c1, "R7");
      drain();

      // R8/R9: random streams under consumer stalls
      cfg_bypass = 1'b0;
      cfg_cut = 32'sd0;
      bp_en = 1'b1;
      for (int k = 0; k < 150; k++) send(rnd_chan(), rnd_chan(), "R8 R5 R6");
      drain();
      cfg_bypass = 1'b1;
      for (int k = 0; k < 100; k++) send(rnd_chan(), rnd_chan(), "R8 R7");
      drain();
      bp_en = 1'b0;
      cfg_bypass = 1'b0;
      cfg_cut = 32'sd20000;
      for (int k = 0; k < 100; k++) send(rnd_chan(), rnd_chan(), "R8 R2 R3 R4");
      drain();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule